// File: doc/BRIEF.md
# Bank Precharge Timing Guard

This block watches the command pins of an eight-bank DDR2-style memory device. It samples them on every rising clock edge and keeps, for each bank, an open or closed flag and three elapsed-time counters: time since the last row open, time since the last close and time since the last read. From these counters it judges each activate, read and precharge against the spacing rules that the configuration inputs set. A command that breaks a rule produces a one-cycle violation pulse. The pulse carries a rule code and the number of the offending bank.

A controller can also use the block before it issues a command. Per-bank ready vectors show, in the current cycle, whether a precharge or an activate to each bank would pass. Every decoded command changes the tracked state, whether or not it was legal, so the guard always follows the bus as it really is. The block has no data path and no handshake. All inputs are plain control pins, and the outputs are plain status.

Top module: `bank_precharge_guard`

## Requirements
- R1: With sel_n low, the pin pattern (row_n, col_n, wr_n) = (0,1,1) is an activate, (1,0,1) is a read and (0,1,0) is a precharge. Any other pattern, and any cycle with sel_n high, changes nothing and raises no violation.
- R2: A precharge with pre_all_sel high closes all eight banks and ignores bank_sel.
- R3: A precharge with pre_all_sel low closes only the bank numbered by bank_sel (0 to 7). The other banks keep their state.
- R4: A precharge to an open bank that comes fewer than cfg_al + cfg_bl/2 clocks after that bank's last read is flagged with code 1. At exactly that spacing it is accepted.
- R5: With cfg_hifreq high, the minimum read-to-precharge spacing grows by one clock to cfg_al + cfg_bl/2 + 1.
- R6: A precharge to an open bank that comes fewer than cfg_tras clocks after that bank's activate is flagged with code 2.
- R7: An activate is flagged with code 3 if fewer than cfg_trp clocks have passed since that bank's last precharge, and with code 4 if fewer than cfg_trc clocks have passed since its last activate. act_ready[b] is high only when bank b is closed and both spacings are met.
- R8: An activate to an open bank, or a read to a closed bank, is flagged with code 5.
- R9: When several rules fail together, the lowest code is reported. For a close-all precharge, the lowest-numbered bank with that code is reported. viol, viol_code and viol_bank are registered and appear in the cycle after the command edge. They are 0 when nothing is flagged.
- R10: Elapsed counters stop at their maximum value. An idle period of any length never causes a false violation and never lowers a ready bit.
- R11: After a synchronous reset, all banks are closed, all spacings count as met (every ready bit is high) and no violation is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Device select, active low |
| row_n | input | 1 | Row strobe pin, active low |
| col_n | input | 1 | Column strobe pin, active low |
| wr_n | input | 1 | Write-enable pin, active low |
| bank_sel | input | 3 | Target bank number |
| pre_all_sel | input | 1 | On a precharge, high closes all banks |
| cfg_al | input | 5 | Additive latency in clocks |
| cfg_bl | input | 5 | Burst length in beats |
| cfg_tras | input | 5 | Minimum activate-to-precharge spacing in clocks |
| cfg_trp | input | 5 | Minimum precharge-to-activate spacing in clocks |
| cfg_trc | input | 5 | Minimum activate-to-activate spacing in clocks for one bank |
| cfg_hifreq | input | 1 | High-clock mode; adds one clock to the read-to-precharge spacing |
| bank_open | output | 8 | Per-bank open flag |
| pre_ready | output | 8 | Per-bank: a precharge now would be accepted |
| act_ready | output | 8 | Per-bank: an activate now would be accepted |
| viol | output | 1 | One-cycle pulse for a flagged command |
| viol_code | output | 3 | Rule code (1 to 5), 0 when idle |
| viol_bank | output | 3 | Bank that triggered the reported code |

## Verification
The bench uses the default build: eight banks and 6-bit elapsed counters, so each counter stops at 63. Timing values are kept small (AL 1, burst 8, tRAS 6, tRP 3, tRC 9). These values let every rule boundary be reached within a few cycles, and idle stretches longer than 63 cycles drive the counters into saturation. A behavioural reference model runs through a directed pass over every code, and then through a long random command stream with long idle gaps and changes to the high-clock mode.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_RD   = 2'd2,
    CMD_PRE  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    VC_NONE  = 3'd0,
    VC_RTP   = 3'd1,
    VC_RAS   = 3'd2,
    VC_RP    = 3'd3,
    VC_RC    = 3'd4,
    VC_STATE = 3'd5
  } vcode_e;

endpackage

// File: rtl/guard_cmd_decode.sv
module guard_cmd_decode
  import bank_guard_pkg::*;
(
  input  logic sel_n,
  input  logic row_n,
  input  logic col_n,
  input  logic wr_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (!sel_n) begin
      unique case ({row_n, col_n, wr_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/guard_sat_counter.sv
module guard_sat_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                count <= TOP;
    else if (restart)       count <= W'(1);
    else if (count != TOP)  count <= count + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (count == TOP && !restart) |=> (count == TOP)); // R10
endmodule

// File: rtl/guard_bank_tracker.sv
module guard_bank_tracker
  import bank_guard_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LIM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_act,
  input  logic             hit_pre,
  input  logic             hit_rd,
  input  logic [LIM_W-1:0] lim_ras,
  input  logic [LIM_W-1:0] lim_rp,
  input  logic [LIM_W-1:0] lim_rc,
  input  logic [LIM_W-1:0] lim_rtp,
  output logic             is_open,
  output logic             pre_ok,
  output logic             act_ok,
  output vcode_e           err
);
  localparam int CW = ((CNT_W > LIM_W) ? CNT_W : LIM_W) + 1;

  logic [CNT_W-1:0] since_act, since_pre, since_rd;
  logic ras_met, rp_met, rc_met, rtp_met;

  guard_sat_counter #(.W(CNT_W)) u_act (
    .clk(clk), .rst(rst), .restart(hit_act), .count(since_act));
  guard_sat_counter #(.W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .restart(hit_pre), .count(since_pre));
  guard_sat_counter #(.W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .restart(hit_rd), .count(since_rd));

  assign ras_met = CW'(since_act) >= CW'(lim_ras);
  assign rc_met  = CW'(since_act) >= CW'(lim_rc);
  assign rp_met  = CW'(since_pre) >= CW'(lim_rp);
  assign rtp_met = CW'(since_rd)  >= CW'(lim_rtp);

  always_ff @(posedge clk) begin
    if (rst)          is_open <= 1'b0;
    else if (hit_pre) is_open <= 1'b0;
    else if (hit_act) is_open <= 1'b1;
  end

  assign pre_ok = !is_open || (ras_met && rtp_met);
  assign act_ok = !is_open && rp_met && rc_met;

  always_comb begin
    err = VC_NONE;
    if (hit_pre && is_open) begin
      if (!rtp_met)      err = VC_RTP;
      else if (!ras_met) err = VC_RAS;
    end else if (hit_act) begin
      if (!rp_met)       err = VC_RP;
      else if (!rc_met)  err = VC_RC;
      else if (is_open)  err = VC_STATE;
    end else if (hit_rd && !is_open) begin
      err = VC_STATE;
    end
  end

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
    (hit_act && !hit_pre) |=> is_open); // R1
  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    hit_pre |=> !is_open); // R3
endmodule

// File: rtl/guard_viol_arbiter.sv
module guard_viol_arbiter
  import bank_guard_pkg::*;
#(
  parameter int NB = 8,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  vcode_e          err [NB],
  output logic            found,
  output vcode_e          best,
  output logic [BW-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    best  = VC_NONE;
    idx   = '0;
    for (int i = 0; i < NB; i++) begin
      if (err[i] != VC_NONE && (!found || err[i] < best)) begin
        found = 1'b1;
        best  = err[i];
        idx   = BW'(i);
      end
    end
  end
endmodule

// File: rtl/bank_precharge_guard.sv
module bank_precharge_guard
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 6,
  parameter int CFG_W     = 5,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LIM_W    = CFG_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_n,
  input  logic                 row_n,
  input  logic                 col_n,
  input  logic                 wr_n,
  input  logic [BA_W-1:0]      bank_sel,
  input  logic                 pre_all_sel,
  input  logic [CFG_W-1:0]     cfg_al,
  input  logic [CFG_W-1:0]     cfg_bl,
  input  logic [CFG_W-1:0]     cfg_tras,
  input  logic [CFG_W-1:0]     cfg_trp,
  input  logic [CFG_W-1:0]     cfg_trc,
  input  logic                 cfg_hifreq,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] pre_ready,
  output logic [NUM_BANKS-1:0] act_ready,
  output logic                 viol,
  output logic [2:0]           viol_code,
  output logic [BA_W-1:0]      viol_bank
);
  cmd_e              cmd;
  logic [LIM_W-1:0]  lim_rtp, lim_ras, lim_rp, lim_rc;
  vcode_e            bank_err [NUM_BANKS];
  logic              any_err;
  vcode_e            top_err;
  logic [BA_W-1:0]   top_bank;

  guard_cmd_decode u_dec (
    .sel_n(sel_n), .row_n(row_n), .col_n(col_n), .wr_n(wr_n), .cmd(cmd));

  assign lim_rtp = LIM_W'(cfg_al) + LIM_W'(cfg_bl >> 1) + LIM_W'(cfg_hifreq);
  assign lim_ras = LIM_W'(cfg_tras);
  assign lim_rp  = LIM_W'(cfg_trp);
  assign lim_rc  = LIM_W'(cfg_trc);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic match;
    assign match = (bank_sel == BA_W'(b));

    guard_bank_tracker #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_trk (
      .clk     (clk),
      .rst     (rst),
      .hit_act (cmd == CMD_ACT && match),
      .hit_pre (cmd == CMD_PRE && (pre_all_sel || match)),
      .hit_rd  (cmd == CMD_RD && match),
      .lim_ras (lim_ras),
      .lim_rp  (lim_rp),
      .lim_rc  (lim_rc),
      .lim_rtp (lim_rtp),
      .is_open (bank_open[b]),
      .pre_ok  (pre_ready[b]),
      .act_ok  (act_ready[b]),
      .err     (bank_err[b])
    );
  end

  guard_viol_arbiter #(.NB(NUM_BANKS)) u_arb (
    .err(bank_err), .found(any_err), .best(top_err), .idx(top_bank));

  always_ff @(posedge clk) begin
    if (rst) begin
      viol      <= 1'b0;
      viol_code <= 3'd0;
      viol_bank <= '0;
    end else begin
      viol      <= any_err;
      viol_code <= top_err;
      viol_bank <= top_bank;
    end
  end

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (bank_open == '0 && !viol && act_ready == '1)); // R11
  AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE && pre_all_sel) |=> (bank_open == '0)); // R2
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    viol |-> (viol_code >= 3'd1 && viol_code <= 3'd5)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !viol |-> (viol_code == 3'd0)); // R9
  AST_ACT_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT && act_ready[bank_sel]) |=> !viol); // R7
  AST_PRE_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE && !pre_all_sel && pre_ready[bank_sel]) |=> !viol); // R4
  AST_NOCMD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NONE) |=> (!viol && $stable(bank_open))); // R1
endmodule

// File: tb/sim_bank_precharge_guard.sv
module sim_bank_precharge_guard;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1;
  logic [2:0] bank_sel = '0;
  logic pre_all_sel = 1'b0;
  logic [4:0] cfg_al = 5'd1, cfg_bl = 5'd8, cfg_tras = 5'd6, cfg_trp = 5'd3, cfg_trc = 5'd9;
  logic cfg_hifreq = 1'b0;
  logic [NB-1:0] bank_open, pre_ready, act_ready;
  logic viol;
  logic [2:0] viol_code, viol_bank;

  always #5 clk = ~clk;

  bank_precharge_guard u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .row_n(row_n), .col_n(col_n), .wr_n(wr_n),
    .bank_sel(bank_sel), .pre_all_sel(pre_all_sel),
    .cfg_al(cfg_al), .cfg_bl(cfg_bl), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
    .cfg_trc(cfg_trc), .cfg_hifreq(cfg_hifreq),
    .bank_open(bank_open), .pre_ready(pre_ready), .act_ready(act_ready),
    .viol(viol), .viol_code(viol_code), .viol_bank(viol_bank));

  int total = 0;
  int bad = 0;
  bit chk_on = 1'b0;
  string cur_tag = "R11";

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int last_act [NB];
  int last_pre [NB];
  int last_rd  [NB];
  bit open_m   [NB];
  int edge_n;
  int exp_code, exp_bank;

  function automatic int rtp_lim();
    return int'(cfg_al) + int'(cfg_bl) / 2 + (cfg_hifreq ? 1 : 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NB; b++) begin
        last_act[b] = -1000; last_pre[b] = -1000; last_rd[b] = -1000; open_m[b] = 0;
      end
      edge_n = 0; exp_code = 0; exp_bank = 0;
    end else begin
      int kind; // 0 none 1 act 2 rd 3 pre
      kind = 0;
      if (!sel_n) begin
        if (!row_n && col_n && wr_n) kind = 1;
        else if (row_n && !col_n && wr_n) kind = 2;
        else if (!row_n && col_n && !wr_n) kind = 3;
      end
      exp_code = 0; exp_bank = 0;
      for (int b = 0; b < NB; b++) begin
        int c;
        bit tgt;
        c = 0;
        tgt = (kind == 3) ? (pre_all_sel || bank_sel == b) : (bank_sel == b);
        if (tgt && kind == 3 && open_m[b]) begin
          if (edge_n - last_rd[b] < rtp_lim()) c = 1;
          else if (edge_n - last_act[b] < int'(cfg_tras)) c = 2;
        end else if (tgt && kind == 1) begin
          if (edge_n - last_pre[b] < int'(cfg_trp)) c = 3;
          else if (edge_n - last_act[b] < int'(cfg_trc)) c = 4;
          else if (open_m[b]) c = 5;
        end else if (tgt && kind == 2 && !open_m[b]) c = 5;
        if (c != 0 && (exp_code == 0 || c < exp_code)) begin
          exp_code = c; exp_bank = b;
        end
      end
      for (int b = 0; b < NB; b++) begin
        if (kind == 1 && bank_sel == b) begin open_m[b] = 1; last_act[b] = edge_n; end
        if (kind == 2 && bank_sel == b) last_rd[b] = edge_n;
        if (kind == 3 && (pre_all_sel || bank_sel == b)) begin open_m[b] = 0; last_pre[b] = edge_n; end
      end
      edge_n++;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      logic [NB-1:0] eo, epr, ear;
      for (int b = 0; b < NB; b++) begin
        eo[b]  = open_m[b];
        epr[b] = !open_m[b] || ((edge_n - last_act[b] >= int'(cfg_tras)) && (edge_n - last_rd[b] >= rtp_lim()));
        ear[b] = !open_m[b] && (edge_n - last_pre[b] >= int'(cfg_trp)) && (edge_n - last_act[b] >= int'(cfg_trc));
      end
      chk(bank_open == eo, cur_tag, "bank_open", bank_open, eo);
      chk(pre_ready == epr, cur_tag, "pre_ready", pre_ready, epr);
      chk(act_ready == ear, cur_tag, "act_ready", act_ready, ear);
      chk(viol == (exp_code != 0), cur_tag, "viol", viol, exp_code != 0);
      chk(viol_code == exp_code, cur_tag, "viol_code", viol_code, exp_code);
      chk(viol_bank == exp_bank, cur_tag, "viol_bank", viol_bank, exp_bank);
    end
  end

  task automatic pins(input bit s, input bit r, input bit c, input bit w, input int b, input bit all);
    sel_n = s; row_n = r; col_n = c; wr_n = w; bank_sel = 3'(b); pre_all_sel = all;
  endtask

  // kind: 1 act, 2 rd, 3 pre; one clock edge, returns at the following negedge
  task automatic issue(input int kind, input int b, input bit all);
    case (kind)
      1: pins(0, 0, 1, 1, b, all);
      2: pins(0, 1, 0, 1, b, all);
      3: pins(0, 0, 1, 0, b, all);
      default: pins(1, 1, 1, 1, b, all);
    endcase
    @(negedge clk);
    pins(1, 1, 1, 1, 0, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_v(input string tag, input int code, input int bank);
    chk(viol == (code != 0), tag, "directed viol", viol, code != 0);
    chk(viol_code == code, tag, "directed code", viol_code, code);
    if (code != 0) chk(viol_bank == bank, tag, "directed bank", viol_bank, bank);
  endtask

  initial begin
    #(10 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_on = 1'b1;
    // R11: state right after reset
    chk(bank_open == 8'h00, "R11", "reset open", bank_open, 0);
    chk(act_ready == 8'hFF, "R11", "reset act_ready", act_ready, 255);
    chk(pre_ready == 8'hFF, "R11", "reset pre_ready", pre_ready, 255);
    chk(viol == 1'b0, "R11", "reset viol", viol, 0);

    cur_tag = "R4";
    issue(1, 0, 0);            // E0
    expect_v("R1", 0, 0);
    chk(bank_open == 8'h01, "R1", "act opens", bank_open, 1);
    issue(2, 0, 0);            // E1
    issue(3, 0, 0);            // E2 read spacing 1
    expect_v("R4", 1, 0);
    cur_tag = "R9";
    issue(1, 0, 0);            // E3 tRP and tRC both short
    expect_v("R9", 3, 0);
    idle(10);
    issue(2, 0, 0);            // E14
    idle(4);
    cur_tag = "R4";
    issue(3, 0, 0);            // E19 spacing exactly 5
    expect_v("R4", 0, 0);
    cur_tag = "R5";
    issue(1, 2, 0);            // E20
    idle(8);
    issue(2, 2, 0);            // E29
    idle(3);
    cfg_hifreq = 1'b1;
    idle(1);
    issue(3, 2, 0);            // E34 spacing 5 < 6
    expect_v("R5", 1, 2);
    cfg_hifreq = 1'b0;
    cur_tag = "R6";
    issue(1, 3, 0);            // E35
    idle(2);
    issue(3, 3, 0);            // E38
    expect_v("R6", 2, 3);
    cur_tag = "R8";
    issue(2, 4, 0);            // E39 read to closed bank
    expect_v("R8", 5, 4);
    issue(1, 5, 0);            // E40
    cur_tag = "R7";
    issue(1, 5, 0);            // E41 tRC short beats state error
    expect_v("R7", 4, 5);
    idle(9);
    cur_tag = "R8";
    issue(1, 5, 0);            // E51 open bank activated again
    expect_v("R8", 5, 5);
    cur_tag = "R2";
    issue(1, 6, 0);            // E52
    idle(10);
    issue(3, 3, 1);            // E63 close all, bank bits 3
    expect_v("R2", 0, 0);
    chk(bank_open == 8'h00, "R2", "all closed", bank_open, 0);
    cur_tag = "R3";
    issue(1, 1, 0);            // E64
    issue(1, 7, 0);            // E65
    idle(9);
    issue(3, 7, 0);            // E75
    expect_v("R3", 0, 0);
    chk(bank_open == 8'h02, "R3", "single close", bank_open, 2);
    cur_tag = "R9";
    issue(1, 4, 0);            // E76
    idle(1);
    issue(3, 0, 1);            // E78 close all, bank 4 too young
    expect_v("R9", 2, 4);
    cur_tag = "R1";
    pins(1, 0, 1, 1, 0, 0);    // select high, activate pattern
    @(negedge clk);
    pins(0, 1, 0, 0, 0, 0);    // write pattern
    @(negedge clk);
    pins(1, 1, 1, 1, 0, 0);
    expect_v("R1", 0, 0);
    chk(bank_open == 8'h00, "R1", "ignored commands", bank_open, 0);
    cur_tag = "R10";
    idle(150);
    chk(act_ready == 8'hFF, "R10", "act_ready after idle", act_ready, 255);
    chk(pre_ready == 8'hFF, "R10", "pre_ready after idle", pre_ready, 255);

    cur_tag = "R7";
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (n % 250 == 0) cfg_hifreq = ~cfg_hifreq;
      if (r < 2) begin
        cur_tag = "R10";
        idle(70 + $urandom_range(0, 10));
        cur_tag = "R7";
      end else if (r < 50) idle(1);
      else if (r < 65) issue(1, $urandom_range(0, 7), 0);
      else if (r < 80) issue(2, $urandom_range(0, 7), 0);
      else if (r < 92) issue(3, $urandom_range(0, 7), ($urandom_range(0, 5) == 0));
      else begin
        pins($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 1));
        @(negedge clk);
        pins(1, 1, 1, 1, 0, 0);
      end
    end
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule